// File: doc/BRIEF.md
# Multi-Layer Background Fetch Sequencer

This block schedules the reads that a line-by-line background renderer makes from a single-port 16-bit video memory. The renderer has no framebuffer, so every pixel must come from data fetched just before it is shown. For each group of 8 dots the sequencer has a budget of 8 read slots. A mode input decides how those slots are split between tilemap entries and tile data. More layers means fewer bits per pixel for each layer. Each slot's request is a plain address, and the memory answers one cycle later.

Fetching for a group runs one group ahead of display. The words that come back are staged per layer. At each group boundary they are unpacked from their planar layout into eight palette indices per layer. Per-layer shift registers then present one index per dot while the next group's reads proceed. A pulse on `line_start` opens the window for one line. The window is 256 visible dots plus an 8-dot lead, and the mode is captured at the same time.

Top module: `bg_fetch_seq`

## Requirements
- R1: While reset is low and just after it, `rd_en` and `pix_valid` are 0 and `pix` is all zeros.
- R2: Counting the cycle after a sampled `line_start` as dot 0, reads are issued only on dots 0 to 255, and never while no line is open. Slot s of group g falls on dot 8g+s.
- R3: Mode code 0 (four layers at 2 bits per pixel) issues the map entries of layers 0, 1, 2, 3 in slots 0 to 3, then one tile word for each of layers 0, 1, 2, 3 in slots 4 to 7.
- R4: Mode code 1 (layers 0 and 1 at 4 bits, layer 2 at 2 bits) issues map entries for layers 0, 1, 2 in slots 0 to 2, then words 0 and 1 of layer 0, words 0 and 1 of layer 1, and word 0 of layer 2.
- R5: Mode code 2 (layer 0 at 8 bits, layer 1 at 2 bits) issues map entries for layers 0 and 1, then words 0 to 3 of layer 0, then word 0 of layer 1. Slot 7 issues no read.
- R6: Mode code 3 issues no reads at all.
- R7: A map read for layer L in group g uses address {1'b0, 8'h00, L[1:0], g[4:0]}. A tile read for word j of layer L uses {1'b1, E[9:0], 3'b000, j[1:0]}, where E is the map entry of layer L returned earlier in the same group.
- R8: `rd_data` is the answer to the read of the previous cycle. Pixel k of group g appears on dot 8g+9+k. `pix_valid` is high exactly on dots 9 to 264, and `pix` is zero whenever `pix_valid` is low.
- R9: The layer at b bits per pixel gets 16/b pixels per word, left to right, with word 0 leftmost. Let h = b/2. Bit p of a pixel's index, at position m within its word, is word bit 8*floor(p/h) + 7 - (p mod h)*(8/h) - m. Layer L's index is on `pix[8L+7:8L]`.
- R10: Layers not used by the current mode output index 0, which means transparent.
- R11: The mode is sampled only with `line_start`. Changing `mode` during a line has no effect on that line's reads or pixels.
- R12: A `line_start` during an open line restarts it at dot 0 with the newly sampled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Opens the fetch window of a line, samples `mode` |
| mode | input | 2 | Slot schedule code 0 to 3 |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | 16 | Word address of the read |
| rd_data | input | 16 | Word returned for the previous cycle's read |
| pix_valid | output | 1 | `pix` carries a visible dot |
| pix | output | 32 | Four 8-bit palette indices, layer L at bits 8L+7:8L |

## Verification
The conditions hardest to reach from the ports are a line restarted part-way through its window and a mode input that moves during a line. In both cases the staging registers still hold words from the earlier schedule. The stimulus pulses `line_start` about a hundred dots into a 2-bit line with a different mode code. It also toggles `mode` during a 4-bit line. A behavioural model, which derives slot order from the per-layer depths and decodes pixels plane by plane, compares every read, address and index on every dot. The memory answers with hashed data that changes from line to line, so stale or misrouted words show up as wrong indices.

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq #(
  parameter int VISIBLE = 256,
  parameter int GROUP   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic [1:0]  mode,
  output logic        rd_en,
  output logic [15:0] rd_addr,
  input  logic [15:0] rd_data,
  output logic        pix_valid,
  output logic [31:0] pix
);
  localparam int LAYERS = 4;
  localparam int IDX_W  = 8;
  localparam int LAST   = VISIBLE + GROUP - 1;
  localparam int DW     = $clog2(LAST + 1);
  localparam int SW     = $clog2(GROUP);
  localparam int SH_W   = IDX_W * GROUP;

  logic          active, pvalid;
  logic [DW-1:0] dot;
  logic [1:0]    mq;
  logic [SW-1:0] slot;
  logic [4:0]    grp;
  logic          s_en, s_tile;
  logic [1:0]    s_ly, s_w;
  logic [2:0]    t;
  logic          rv_en, rv_tile;
  logic [1:0]    rv_ly, rv_w;
  logic [LAYERS-1:0][15:0]      ent;
  logic [LAYERS-1:0][3:0][15:0] wd, wd_n;
  logic [LAYERS-1:0][SH_W-1:0]  sh;
  logic          load;

  assign slot = dot[SW-1:0];
  assign grp  = 5'(dot >> SW);
  assign t    = slot - 3'd3;

  always_comb begin
    s_en = 1'b0; s_tile = 1'b0; s_ly = 2'd0; s_w = 2'd0;
    case (mq)
      2'd0: begin
        s_en = 1'b1; s_tile = slot[2]; s_ly = slot[1:0];
      end
      2'd1: begin
        s_en = 1'b1;
        if (slot < 3'd3) s_ly = slot[1:0];
        else begin s_tile = 1'b1; s_ly = t[2:1]; s_w = {1'b0, t[0]}; end
      end
      2'd2: if (slot != 3'd7) begin
        s_en = 1'b1;
        if (slot < 3'd2) s_ly = slot[1:0];
        else if (slot < 3'd6) begin s_tile = 1'b1; s_w = 2'(slot - 3'd2); end
        else begin s_tile = 1'b1; s_ly = 2'd1; end
      end
      default: ;
    endcase
  end

  assign rd_en   = active && (dot < DW'(VISIBLE)) && s_en;
  assign rd_addr = s_tile ? {1'b1, ent[s_ly][9:0], 3'b000, s_w}
                          : {1'b0, 8'h00, s_ly, grp};

  always_comb begin
    wd_n = wd;
    if (rv_en && rv_tile) wd_n[rv_ly][rv_w] = rd_data;
  end

  function automatic logic [1:0] depth(input logic [1:0] m, input int l);
    case (m)
      2'd0:    return 2'd1;
      2'd1:    return (l < 2) ? 2'd2 : ((l == 2) ? 2'd1 : 2'd0);
      2'd2:    return (l == 0) ? 2'd3 : ((l == 1) ? 2'd1 : 2'd0);
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [SH_W-1:0] unpack(input logic [1:0] dp,
                                             input logic [3:0][15:0] w);
    logic [SH_W-1:0] r;
    int bpp, h, per, j, m, bi;
    r = '0;
    if (dp != 2'd0) begin
      bpp = 1 << int'(dp);
      h   = bpp / 2;
      per = 8 / h;
      for (int p = 0; p < GROUP; p++) begin
        j = p / per;
        m = p % per;
        for (int b = 0; b < IDX_W; b++)
          if (b < bpp) begin
            bi = 8 * (b / h) + 7 - (b % h) * per - m;
            r[SH_W - IDX_W - IDX_W * p + b] = w[j][bi];
          end
      end
    end
    return r;
  endfunction

  assign load = active && (slot == '0) && (dot != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; pvalid <= 1'b0; dot <= '0; mq <= 2'd0;
      rv_en <= 1'b0; rv_tile <= 1'b0; rv_ly <= 2'd0; rv_w <= 2'd0;
      ent <= '0; wd <= '0; sh <= '0;
    end else begin
      rv_en <= rd_en; rv_tile <= s_tile; rv_ly <= s_ly; rv_w <= s_w;
      wd <= wd_n;
      if (rv_en && !rv_tile) ent[rv_ly] <= rd_data;
      for (int l = 0; l < LAYERS; l++)
        sh[l] <= load ? unpack(depth(mq, l), wd_n[l]) : (sh[l] << IDX_W);
      if (line_start) begin
        active <= 1'b1; dot <= '0; mq <= mode; pvalid <= 1'b0;
      end else if (active) begin
        dot    <= dot + 1'b1;
        pvalid <= dot >= DW'(GROUP);
        if (dot == DW'(LAST)) active <= 1'b0;
      end else begin
        pvalid <= 1'b0;
      end
    end
  end

  assign pix_valid = pvalid;
  for (genvar l = 0; l < LAYERS; l++) begin : g_out
    assign pix[IDX_W*l +: IDX_W] = pvalid ? sh[l][SH_W-1 -: IDX_W] : '0;
  end
endmodule

module bg_fetch_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_start,
  input logic        rd_en,
  input logic [15:0] rd_addr,
  input logic        pix_valid,
  input logic [31:0] pix,
  input logic        active,
  input logic [8:0]  dot,
  input logic [1:0]  mq
);
  p_read_needs_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ($past(active) || $past(line_start)));
  p_quad_tile_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mq == 2'd0) |-> (rd_addr[15] == dot[2]));
  p_wide_idle_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mq == 2'd2 && dot[2:0] == 3'd7) |-> !rd_en);
  p_blank_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mq == 2'd3) |-> !rd_en);
  p_valid_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(active));
  p_blank_pix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mq == 2'd3) |-> (pix == 32'd0));
  p_hold_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !line_start) |=> $stable(mq));
endmodule

bind bg_fetch_seq bg_fetch_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .rd_en(rd_en),
  .rd_addr(rd_addr), .pix_valid(pix_valid), .pix(pix), .active(active),
  .dot(dot), .mq(mq)
);

// File: tb/tb_bg_fetch_seq.sv
module tb_bg_fetch_seq;
  logic        clk = 0, rst_n = 0, line_start = 0;
  logic [1:0]  mode = 0;
  logic        rd_en, pix_valid;
  logic [15:0] rd_addr, rd_data;
  logic [31:0] pix;
  int tests = 0, fails = 0, seed = 0, e_dot = -1, cyc = 0;
  logic [1:0] e_mode = 0;
  string scen = "";
  bit run_chk = 0, done = 0;

  bg_fetch_seq dut (.clk(clk), .rst_n(rst_n), .line_start(line_start), .mode(mode),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pix_valid(pix_valid), .pix(pix));

  always #5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [31:0] x;
    x = {16'h0, a} * 32'd40503 + 32'(seed) * 32'd7919;
    return x[15:0] ^ x[31:16] ^ {a[7:0], a[15:8]};
  endfunction

  always @(posedge clk) rd_data <= rd_en ? memf(rd_addr) : 16'hDEAD;

  always @(posedge clk) begin
    if (!rst_n) e_dot = -1;
    else if (line_start) begin e_dot = 0; e_mode = mode; end
    else if (e_dot >= 0) begin e_dot++; if (e_dot > 264) e_dot = -1; end
  end

  function automatic int bpp_of(input logic [1:0] md, input int l);
    int t[4];
    case (md)
      2'd0: t = '{2, 2, 2, 2};
      2'd1: t = '{4, 4, 2, 0};
      2'd2: t = '{8, 2, 0, 0};
      default: t = '{0, 0, 0, 0};
    endcase
    return t[l];
  endfunction

  function automatic logic [15:0] map_a(input int l, input int g);
    return {1'b0, 8'h00, 2'(l), 5'(g)};
  endfunction

  function automatic logic [15:0] tile_a(input int l, input int g, input int j);
    logic [15:0] e;
    e = memf(map_a(l, g));
    return {1'b1, e[9:0], 3'b000, 2'(j)};
  endfunction

  task automatic exp_slot(input logic [1:0] md, input int s, output bit en,
                          output bit tile, output int ly, output int w);
    int idx;
    idx = 0; en = 0; tile = 0; ly = 0; w = 0;
    for (int l = 0; l < 4; l++)
      if (bpp_of(md, l) > 0) begin
        if (idx == s) begin en = 1; ly = l; end
        idx++;
      end
    for (int l = 0; l < 4; l++)
      for (int j = 0; j < bpp_of(md, l) / 2; j++) begin
        if (idx == s) begin en = 1; tile = 1; ly = l; w = j; end
        idx++;
      end
  endtask

  function automatic logic [7:0] exp_pix(input logic [1:0] md, input int l, input int d);
    int g, k, m;
    logic [15:0] wv;
    g = (d - 9) / 8; k = (d - 9) % 8;
    case (bpp_of(md, l))
      2: begin
        wv = memf(tile_a(l, g, 0));
        return {6'd0, wv[15-k], wv[7-k]};
      end
      4: begin
        wv = memf(tile_a(l, g, k / 4)); m = k % 4;
        return {4'd0, wv[11-m], wv[15-m], wv[3-m], wv[7-m]};
      end
      8: begin
        wv = memf(tile_a(l, g, k / 2)); m = k % 2;
        return {wv[9-m], wv[11-m], wv[13-m], wv[15-m],
                wv[1-m], wv[3-m], wv[5-m], wv[7-m]};
      end
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s dot=%0d actual=%h expected=%h", req, what, e_dot, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && run_chk) begin
    bit en, tile, ev;
    int ly, w, d;
    string tg;
    logic [15:0] ea;
    d = e_dot;
    en = 0; tile = 0; ly = 0; w = 0;
    if (d >= 0 && d < 256) exp_slot(e_mode, d % 8, en, tile, ly, w);
    if (d >= 0 && d < 256)
      tg = (e_mode == 0) ? "R3" : (e_mode == 1) ? "R4" : (e_mode == 2) ? "R5" : "R6";
    else tg = "R2";
    chk(scen != "" ? scen : tg, {31'd0, rd_en}, {31'd0, en}, "rd_en");
    if (en && rd_en) begin
      ea = tile ? tile_a(ly, d / 8, w) : map_a(ly, d / 8);
      chk(scen != "" ? scen : "R7", {16'd0, rd_addr}, {16'd0, ea}, "rd_addr");
    end
    ev = (d >= 9 && d <= 264);
    chk(scen != "" ? scen : "R8", {31'd0, pix_valid}, {31'd0, ev}, "pix_valid");
    for (int l = 0; l < 4; l++) begin
      tg = !ev ? "R8" : (bpp_of(e_mode, l) == 0) ? "R10" : "R9";
      chk(scen != "" ? scen : tg, {24'd0, pix[8*l +: 8]},
          {24'd0, ev ? exp_pix(e_mode, l, d) : 8'd0}, $sformatf("pix layer %0d", l));
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1; fails++; tests++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
    end
  end

  task automatic start_line(input logic [1:0] md);
    @(negedge clk); mode = md; line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    chk("R1", {31'd0, rd_en}, 0, "rd_en in reset");
    chk("R1", {31'd0, pix_valid}, 0, "pix_valid in reset");
    chk("R1", pix, 0, "pix in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", {31'd0, rd_en}, 0, "rd_en after reset");
    chk("R1", {31'd0, pix_valid}, 0, "pix_valid after reset");
    run_chk = 1;
    wait_cyc(3);
    for (int md = 0; md < 4; md++) begin
      seed = md + 1;
      start_line(2'(md));
      wait_cyc(272);
    end
    seed = 11; scen = "R11";
    start_line(2'd1);
    wait_cyc(40); mode = 2'd2;
    wait_cyc(60); mode = 2'd0;
    wait_cyc(172);
    scen = ""; seed = 12;
    start_line(2'd0);
    wait_cyc(100);
    scen = "R12";
    start_line(2'd2);
    wait_cyc(272);
    scen = ""; seed = 13;
    start_line(2'd2);
    wait_cyc(272);
    done = 1;
    summary();
  end
endmodule